// File: doc/BRIEF.md
# Interleaved Strided Memory Bank Scheduler

This block takes a vector memory request (a base word address, a signed stride and an element count) and spreads its word accesses over a group of word-interleaved memory banks. The bank index of each word is the low bits of its word address. In every clock cycle up to sixteen 8-byte words go out, each on its own bank. For every bank the block drives an enable, the full word address and the index of the vector element. A memory controller can therefore run all banks in parallel, and the element index lets returned data be put back in order.

A bank that has just taken an access needs one more clock to recover. The block never sends a word to such a bank, and never sends two words of one cycle to the same bank. Elements go out strictly in element order. The first element that cannot go out in a cycle ends that cycle's group, and it is tried again in the next cycle. No word is ever dropped. Contiguous and evenly spaced streams keep the full sixteen words per cycle whenever their bank pattern allows it. A single-cycle completion pulse marks the cycle that carries the final words. The request side is a valid/ready handshake, and only one request is in flight at a time.

Top module: `strided_bank_sched`

## Requirements
- R1: After synchronous reset, every bank enable and the completion pulse are low, and the request ready is high.
- R2: An enabled bank b carries the full 32-bit word address of the element it serves, and bits [4:0] of that address equal b (32 banks). It also carries the element number of that element as an 8-bit index counted from 0.
- R3: The address of element k is base + k × stride modulo 2^32. The stride is a 16-bit two's-complement value, sign-extended before use.
- R4: In a cycle, at most 16 banks are enabled and each bank serves at most one element.
- R5: A bank that is enabled in one cycle is not enabled in the next cycle.
- R6: Each cycle serves the longest run of consecutive pending elements whose banks are all free, capped at 16. A free bank is one that was not enabled in the previous cycle and is not already used by an earlier element of the run. The first blocked element, and every element after it, waits for a later cycle.
- R7: The number of bank enables over a request equals its length (1 to 256). Each element number appears exactly once.
- R8: A unit-stride request of length 256 needs exactly 16 issue cycles. A stride-32 request of length 256 sends one word every second cycle, so it spans 511 cycles.
- R9: The completion pulse is high for one cycle, and that cycle is the one whose bank enables carry the final elements. In that same cycle, request ready is high again.
- R10: Request ready is low from the cycle after acceptance until the completion cycle. A request presented while ready is low is ignored and does not change the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block is idle and will take a request |
| req_base | input | 32 | Word address of element 0 |
| req_stride | input | 16 | Signed element-to-element word distance |
| req_len | input | 9 | Element count, 1 to 256 |
| bank_en | output | 32 | One enable per bank for this cycle |
| bank_addr | output | 32x32 | Word address per bank |
| bank_elem | output | 32x8 | Element index per bank |
| done | output | 1 | Pulse marking the final issue cycle |

## Verification
Two kinds of deferral can fall in the same cycle. One is a word that lands on a bank still recovering from the previous cycle. The other is a word that repeats a bank already taken earlier in the current group. Strides such as 0, 2, 32 and 48, together with random 16-bit strides and lengths, make both kinds collide within a single group. Each cycle, the bench compares the bank enables, the addresses and the element indices with a greedy in-order model built from the requirements. Completion and the element count must then line up with that model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int ADDR_W   = 32;
    localparam int NBANK    = 32;
    localparam int BANK_W   = $clog2(NBANK);
    localparam int LANES    = 16;
    localparam int STRIDE_W = 16;
    localparam int MAX_LEN  = 256;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam int IDX_W    = $clog2(MAX_LEN);
    localparam int CNT_W    = $clog2(LANES + 1);

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [IDX_W-1:0]  elem_t;
    typedef logic [NBANK-1:0]  bmask_t;
    typedef logic [LANES-1:0]  lmask_t;

    typedef struct packed {
        logic   vld;
        waddr_t addr;
        bank_t  bank;
        elem_t  elem;
    } lane_t;

    function automatic bank_t bank_of(waddr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic waddr_t widen_stride(logic [STRIDE_W-1:0] s);
        return {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
    endfunction

endpackage

// File: rtl/sbs_lane_gen.sv
module sbs_lane_gen
    import sbs_pkg::*;
(
    input  waddr_t                cur_addr,
    input  waddr_t                stride,
    input  logic [LEN_W-1:0]      cur_idx,
    input  logic [LEN_W-1:0]      total_len,
    output lane_t [LANES-1:0]     lanes
);

    logic [LEN_W-1:0] remain;
    assign remain = total_len - cur_idx;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        waddr_t           a;
        logic [LEN_W-1:0] e;
        assign a = cur_addr + waddr_t'(k) * stride;
        assign e = cur_idx + LEN_W'(k);
        assign lanes[k] = '{
            vld:  (LEN_W'(k) < remain),
            addr: a,
            bank: bank_of(a),
            elem: e[IDX_W-1:0]
        };
    end

endmodule

// File: rtl/sbs_issue_sel.sv
module sbs_issue_sel
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  lane_t [LANES-1:0] lanes,
    input  bmask_t            busy,
    output lmask_t            issue,
    output logic [CNT_W-1:0]  issue_cnt
);

    bmask_t used;
    logic   go;

    always_comb begin
        used      = '0;
        go        = run;
        issue     = '0;
        issue_cnt = '0;
        for (int k = 0; k < LANES; k++) begin
            if (go && lanes[k].vld && !busy[lanes[k].bank] && !used[lanes[k].bank]) begin
                issue[k]            = 1'b1;
                used[lanes[k].bank] = 1'b1;
                issue_cnt           = issue_cnt + 1'b1;
            end else begin
                go = 1'b0;
            end
        end
    end

    // R6: the issued lanes always form an unbroken run starting at lane 0
    p_in_order_r6: assert property (@(posedge clk) disable iff (rst)
        ((issue & (issue + 1'b1)) == '0));

    // R4: count agrees with the mask handed to the router
    p_cnt_match_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(issue) == int'(issue_cnt)));

endmodule

// File: rtl/sbs_bank_route.sv
module sbs_bank_route
    import sbs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  lane_t [LANES-1:0]             lanes,
    input  lmask_t                        issue,
    output bmask_t                        en,
    output logic [NBANK-1:0][ADDR_W-1:0]  addr,
    output logic [NBANK-1:0][IDX_W-1:0]   elem
);

    logic [NBANK-1:0][LANES-1:0] hits;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar k = 0; k < LANES; k++) begin : g_hit
            assign hits[b][k] = issue[k] && (lanes[k].bank == bank_t'(b));
        end

        always_comb begin
            en[b]   = |hits[b];
            addr[b] = '0;
            elem[b] = '0;
            for (int k = 0; k < LANES; k++) begin
                if (hits[b][k]) begin
                    addr[b] = lanes[k].addr;
                    elem[b] = lanes[k].elem;
                end
            end
        end

        // R4: a bank never serves two elements in one cycle
        p_one_per_bank_r4: assert property (@(posedge clk) disable iff (rst)
            ($onehot0(hits[b])));
    end

endmodule

// File: rtl/strided_bank_sched.sv
module strided_bank_sched
    import sbs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_base,
    input  logic [STRIDE_W-1:0]           req_stride,
    input  logic [LEN_W-1:0]              req_len,
    output logic [NBANK-1:0]              bank_en,
    output logic [NBANK-1:0][ADDR_W-1:0]  bank_addr,
    output logic [NBANK-1:0][IDX_W-1:0]   bank_elem,
    output logic                          done
);

    logic             active;
    waddr_t           cur_addr;
    waddr_t           stride_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;

    lane_t [LANES-1:0]            lanes;
    lmask_t                       issue;
    logic [CNT_W-1:0]             issue_cnt;
    bmask_t                       r_en;
    logic [NBANK-1:0][ADDR_W-1:0] r_addr;
    logic [NBANK-1:0][IDX_W-1:0]  r_elem;
    logic [LEN_W-1:0]             idx_next;
    logic                         finishing;

    sbs_lane_gen u_lanes (
        .cur_addr  (cur_addr),
        .stride    (stride_q),
        .cur_idx   (idx_q),
        .total_len (len_q),
        .lanes     (lanes)
    );

    sbs_issue_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .run       (active),
        .lanes     (lanes),
        .busy      (bank_en),
        .issue     (issue),
        .issue_cnt (issue_cnt)
    );

    sbs_bank_route u_route (
        .clk   (clk),
        .rst   (rst),
        .lanes (lanes),
        .issue (issue),
        .en    (r_en),
        .addr  (r_addr),
        .elem  (r_elem)
    );

    assign idx_next  = idx_q + LEN_W'(issue_cnt);
    assign finishing = active && (idx_next == len_q);
    assign req_ready = !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cur_addr  <= '0;
            stride_q  <= '0;
            idx_q     <= '0;
            len_q     <= '0;
            bank_en   <= '0;
            bank_addr <= '0;
            bank_elem <= '0;
            done      <= 1'b0;
        end else begin
            bank_en   <= r_en;
            bank_addr <= r_addr;
            bank_elem <= r_elem;
            done      <= finishing;
            if (!active) begin
                if (req_valid) begin
                    active   <= 1'b1;
                    cur_addr <= req_base;
                    stride_q <= widen_stride(req_stride);
                    idx_q    <= '0;
                    len_q    <= req_len;
                end
            end else begin
                cur_addr <= cur_addr + waddr_t'(issue_cnt) * stride_q;
                idx_q    <= idx_next;
                if (finishing) begin
                    active <= 1'b0;
                end
            end
        end
    end

    // R5: a bank gets a recovery cycle after every access
    p_bank_rest_r5: assert property (@(posedge clk) disable iff (rst)
        ((bank_en & $past(bank_en)) == '0));

    // R4: never more words than lanes in one cycle
    p_lane_limit_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(bank_en) <= LANES));

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: an accepted request closes the door in the next cycle
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/strided_bank_sched_test.sv
`timescale 1ns/1ps
module strided_bank_sched_test;
    import sbs_pkg::*;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic                         req_valid;
    logic                         req_ready;
    logic [ADDR_W-1:0]            req_base;
    logic [STRIDE_W-1:0]          req_stride;
    logic [LEN_W-1:0]             req_len;
    logic [NBANK-1:0]             bank_en;
    logic [NBANK-1:0][ADDR_W-1:0] bank_addr;
    logic [NBANK-1:0][IDX_W-1:0]  bank_elem;
    logic                         done;

    strided_bank_sched uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_stride(req_stride), .req_len(req_len),
        .bank_en(bank_en), .bank_addr(bank_addr), .bank_elem(bank_elem),
        .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model state
    logic [31:0]       m_base, m_stride;
    int                m_len, m_idx;
    logic [31:0]       m_busy, exp_en;
    logic [31:0]       exp_addr [32];
    logic [7:0]        exp_elem [32];

    function automatic logic [31:0] elem_addr(input int k);
        return m_base + 32'(k) * m_stride;
    endfunction

    task automatic model_step();
        logic [31:0] used;
        int cnt;
        bit go;
        used = '0; cnt = 0; go = 1'b1;
        for (int k = 0; k < 16; k++) begin
            int e;
            logic [31:0] a;
            e = m_idx + k;
            if (go && e < m_len) begin
                a = elem_addr(e);
                if (!m_busy[a[4:0]] && !used[a[4:0]]) begin
                    used[a[4:0]] = 1'b1;
                    exp_addr[a[4:0]] = a;
                    exp_elem[a[4:0]] = 8'(e);
                    cnt++;
                end else go = 1'b0;
            end else go = 1'b0;
        end
        m_idx  = m_idx + cnt;
        m_busy = used;
        exp_en = used;
    endtask

    task automatic run_req(input logic [31:0] base, input logic [15:0] stride,
                           input int len, input bit poke, output int cycles);
        int  issued;
        bit  fin;
        bit  bad;
        logic [63:0] bad_a, bad_e;
        req_base = base; req_stride = stride; req_len = 9'(len); req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10", "ready before request", 64'(req_ready), 64'd1);
        m_base = base; m_stride = widen_stride(stride); m_len = len;
        m_idx = 0; m_busy = '0;
        issued = 0; cycles = 0; fin = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready after accept", 64'(req_ready), 64'd0);
        while (!fin && cycles < 1000) begin
            if (poke && cycles == 1) begin
                chk(req_ready == 1'b0, "R10", "ready mid stream", 64'(req_ready), 64'd0);
                req_valid = 1'b1; req_base = ~base; req_stride = 16'h0005; req_len = 9'd7;
            end
            @(negedge clk);
            req_valid = 1'b0;
            cycles++;
            model_step();
            // R4 R5 R6: which banks go this cycle
            chk(bank_en == exp_en, "R6", "bank enables", 64'(bank_en), 64'(exp_en));
            bad = 1'b0; bad_a = '0; bad_e = '0;
            for (int b = 0; b < 32; b++) begin
                if (exp_en[b] && bank_en[b] &&
                    (bank_addr[b] != exp_addr[b] || bank_elem[b] != exp_elem[b])) begin
                    bad = 1'b1;
                    bad_a = {bank_addr[b], 24'd0, bank_elem[b]};
                    bad_e = {exp_addr[b], 24'd0, exp_elem[b]};
                end
            end
            // R2 R3: address and element index on each bank
            chk(!bad, "R3", "bank address/element", bad_a, bad_e);
            issued += $countones(bank_en);
            fin = (m_idx == m_len);
            chk(done == fin, "R9", "completion pulse", 64'(done), 64'(fin));
        end
        chk(issued == len, "R7", "words issued", 64'(issued), 64'(len));
        chk(req_ready == 1'b1, "R9", "ready at completion", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int seed;
        logic [15:0] s;
        seed = $urandom(32'd20240611);
        req_valid = 1'b0; req_base = '0; req_stride = '0; req_len = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(bank_en == '0, "R1", "bank enables after reset", 64'(bank_en), 64'd0);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        @(negedge clk);

        // R8: unit stride, full length, 16 cycles
        run_req(32'h0000_0000, 16'd1, 256, 1'b0, cyc);
        chk(cyc == 16, "R8", "unit stride cycles", 64'(cyc), 64'd16);
        run_req(32'h0000_1005, 16'd1, 256, 1'b0, cyc);
        chk(cyc == 16, "R8", "unit stride offset cycles", 64'(cyc), 64'd16);
        // R8: stride 32 lands on one bank
        run_req(32'h0000_0040, 16'd32, 256, 1'b0, cyc);
        chk(cyc == 511, "R8", "stride-32 cycles", 64'(cyc), 64'd511);
        // R5: zero stride, three words, every second cycle
        run_req(32'h0000_0007, 16'd0, 3, 1'b0, cyc);
        chk(cyc == 5, "R5", "zero stride cycles", 64'(cyc), 64'd5);
        // R7: single element
        run_req(32'h1234_5678, 16'hFFFF, 1, 1'b0, cyc);
        chk(cyc == 1, "R7", "single element cycles", 64'(cyc), 64'd1);
        // R3: wrap across the top of the address space, negative strides
        run_req(32'hFFFF_FFF8, 16'd1, 20, 1'b0, cyc);
        run_req(32'h0000_0003, 16'hFFFF, 40, 1'b0, cyc);
        run_req(32'h0000_0010, 16'h8000, 30, 1'b0, cyc);
        // R10: request poked while busy is ignored
        run_req(32'h0000_0100, 16'd2, 200, 1'b1, cyc);
        run_req(32'h0000_0200, 16'd48, 100, 1'b1, cyc);

        // random mix
        for (int i = 0; i < 30; i++) begin
            case ($urandom % 4)
                0: s = 16'($signed($urandom % 9) - 4);
                1: s = 16'($signed($urandom % 17) - 8) * 16'd8;
                2: s = 16'($urandom);
                default: s = ($urandom % 2) ? 16'd1 : 16'hFFFF;
            endcase
            run_req($urandom, s, 1 + int'($urandom % 256), 1'b0, cyc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule